// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes one active-low interrupt pin from outside the chip and turns it into an interrupt request for the CPU. The pin first crosses into the clock domain through a short flop chain. It is then read in one of two ways. In level mode, the request follows the pin while the pin is low. In edge mode, a falling edge is stored in a pending latch, and the request stays up until the CPU acknowledges it.

Software sees one control byte on a small synchronous bus, and that byte has two live bits. An enable bit joins the pin to the request output or cuts it off; software can change it at any time. A mode bit picks edge or level detection. In normal operation the mode bit takes only the first write after reset and ignores every later one. While the special-mode input is high, the mode bit can be rewritten freely. The bus has no flow control: a write takes effect on the clock edge where chip select and write enable are both high. Read data is presented combinationally at all times.

Top module: `irq_pin_ctrl`

## Requirements
- R1: After reset, the mode bit (bit 7) is 0, meaning level mode. The enable bit (bit 6) is 1. No edge is pending. `bus_rdata` reads 0x40 and `irq_req` is low while the pin is high.
- R2: Bits 5 to 0 of `bus_rdata` always read 0, whatever value was written to them.
- R3: In level mode with enable set, `irq_req` goes high on the second rising clock edge after the pin goes low. It drops on the second edge after the pin returns high. An acknowledge has no effect on it.
- R4: In edge mode, a falling pin edge sets the pending latch one edge after it is seen on the synchronized pin. `irq_req` then stays high after the pin returns high.
- R5: An acknowledge pulse clears the pending latch, and `irq_req` is low from the following clock edge.
- R6: If an acknowledge falls in the same cycle as a newly detected falling edge, the edge wins and the latch stays set.
- R7: With enable at 0, `irq_req` stays low. Edges are still captured in edge mode and show up as a request once enable is written to 1.
- R8: With `special_mode` low, the first write after reset sets the mode bit and locks it. Later writes leave the mode bit unchanged.
- R9: With `special_mode` high, every write updates the mode bit. Such writes do not set the lock.
- R10: Every write updates the enable bit, in either mode and whether or not the lock is set.
- R11: In edge mode, a pin that stays low after its request has been serviced raises no further request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| special_mode | input | 1 | High selects special operation, in which the mode bit is freely writable |
| bus_cs | input | 1 | Control register select |
| bus_we | input | 1 | Write strobe, qualified by `bus_cs` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control register read value |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| irq_ack | input | 1 | Service acknowledge, clears a pending edge |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach is an acknowledge that lands in exactly the same cycle as a newly detected falling edge. That cycle is the one just after the second synchronizer stage samples the low pin. To hit it, the bench drives the pin on a falling clock edge, waits two falling edges, and raises the acknowledge for one cycle. A pending edge is set up beforehand, so a design that gives the acknowledge priority shows up as a dropped request. The write lock is also tested across a change of mode: writes made in special mode must leave the first normal-mode write still able to set the mode bit.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  parameter int unsigned CTRL_W   = 8;
  parameter int unsigned EDGE_BIT = 7;
  parameter int unsigned EN_BIT   = 6;

  typedef struct packed {
    logic edge_sel;
    logic enable;
  } irq_cfg_t;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import ext_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  special_mode,
  input  logic                  wr_en,
  input  logic [CTRL_W-1:0]     wdata,
  output irq_cfg_t              cfg,
  output logic                  locked
);
  irq_cfg_t cfg_q;
  logic     lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.edge_sel <= 1'b0;
      cfg_q.enable   <= 1'b1;
      lock_q         <= 1'b0;
    end else if (wr_en) begin
      cfg_q.enable <= wdata[EN_BIT];
      if (special_mode || !lock_q)
        cfg_q.edge_sel <= wdata[EDGE_BIT];
      if (!special_mode)
        lock_q <= 1'b1;
    end
  end

  assign cfg    = cfg_q;
  assign locked = lock_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  input  logic edge_mode,
  input  logic enable,
  input  logic ack,
  output logic fall,
  output logic pending,
  output logic req
);
  logic prev_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_n;
  end

  assign fall = prev_q & ~sync_n;

  // a new edge outranks a simultaneous acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pend_q <= 1'b0;
    else if (edge_mode && fall) pend_q <= 1'b1;
    else if (ack)              pend_q <= 1'b0;
  end

  assign pending = pend_q;
  assign req     = enable & (edge_mode ? pend_q : ~sync_n);
endmodule

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              special_mode,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              irq_pin_n,
  input  logic              irq_ack,
  output logic              irq_req
);
  irq_cfg_t cfg;
  logic     wr_lock;
  logic     pin_sync_n;
  logic     fall_det;
  logic     pend_q;
  logic     edge_sel;
  logic     irq_en;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n  (irq_pin_n),
    .sync_n (pin_sync_n)
  );

  irq_ctrl_reg u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .wr_en        (bus_cs & bus_we),
    .wdata        (bus_wdata),
    .cfg          (cfg),
    .locked       (wr_lock)
  );

  assign edge_sel = cfg.edge_sel;
  assign irq_en   = cfg.enable;

  irq_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n    (pin_sync_n),
    .edge_mode (edge_sel),
    .enable    (irq_en),
    .ack       (irq_ack),
    .fall      (fall_det),
    .pending   (pend_q),
    .req       (irq_req)
  );

  always_comb begin
    bus_rdata           = '0;
    bus_rdata[EDGE_BIT] = edge_sel;
    bus_rdata[EN_BIT]   = irq_en;
  end
endmodule

// File: rtl/irq_pin_ctrl_chk.sv
module irq_pin_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              special_mode,
  input logic              bus_cs,
  input logic              bus_we,
  input logic [CTRL_W-1:0] bus_wdata,
  input logic [CTRL_W-1:0] bus_rdata,
  input logic              irq_ack,
  input logic              irq_req,
  input logic              edge_sel,
  input logic              irq_en,
  input logic              wr_lock,
  input logic              fall_det,
  input logic              pend_q
);
  // R2
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[EN_BIT-1:0] == '0);

  // R4
  edge_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel && fall_det) |=> pend_q);

  // R5
  ack_clears_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !fall_det) |=> !pend_q);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_req);

  // R8
  locked_mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lock && !special_mode && bus_cs && bus_we) |=> $stable(edge_sel));

  // R10
  enable_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we) |=> (irq_en == $past(bus_wdata[EN_BIT])));
endmodule

bind irq_pin_ctrl irq_pin_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .special_mode (special_mode),
  .bus_cs       (bus_cs),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq_ack      (irq_ack),
  .irq_req      (irq_req),
  .edge_sel     (edge_sel),
  .irq_en       (irq_en),
  .wr_lock      (wr_lock),
  .fall_det     (fall_det),
  .pend_q       (pend_q)
);

// File: tb/tb_irq_pin_ctrl.sv
module tb_irq_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       special_mode = 1'b0;
  logic       bus_cs = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_pin_n = 1'b1;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_pin_ctrl dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .special_mode (special_mode),
    .bus_cs       (bus_cs),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .irq_pin_n    (irq_pin_n),
    .irq_ack      (irq_ack),
    .irq_req      (irq_req)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; special_mode = 1'b0; irq_pin_n = 1'b1; irq_ack = 1'b0;
    bus_cs = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rdata", bus_rdata, 8'h40);
    check("R1 irq_req", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_level();
    do_reset();
    irq_pin_n = 1'b0;
    @(negedge clk);
    check("R3 one edge", {7'b0, irq_req}, 8'h00);
    @(negedge clk);
    check("R3 two edges", {7'b0, irq_req}, 8'h01);
    ack_pulse();
    check("R3 ack ignored", {7'b0, irq_req}, 8'h01);
    irq_pin_n = 1'b1;
    @(negedge clk);
    check("R3 release one edge", {7'b0, irq_req}, 8'h01);
    @(negedge clk);
    check("R3 release two edges", {7'b0, irq_req}, 8'h00);
  endtask

  task automatic t_edge();
    do_reset();
    wr(8'hC0);
    check("R8 first write", bus_rdata, 8'hC0);
    irq_pin_n = 1'b0;
    idle(3);
    check("R4 edge caught", {7'b0, irq_req}, 8'h01);
    irq_pin_n = 1'b1;
    idle(3);
    check("R4 held after release", {7'b0, irq_req}, 8'h01);
    ack_pulse();
    check("R5 cleared", {7'b0, irq_req}, 8'h00);
    irq_pin_n = 1'b0;
    idle(3);
    check("R4 second edge", {7'b0, irq_req}, 8'h01);
    ack_pulse();
    idle(4);
    check("R11 steady low quiet", {7'b0, irq_req}, 8'h00);
    irq_pin_n = 1'b1;
    idle(3);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'hC0);
    wr(8'h40);
    check("R8 mode kept", bus_rdata, 8'hC0);
    wr(8'h80);
    check("R10 enable cleared while locked", bus_rdata, 8'h80);
    wr(8'hFF);
    check("R2 low bits zero", bus_rdata, 8'hC0);
  endtask

  task automatic t_special();
    do_reset();
    special_mode = 1'b1;
    wr(8'h80);
    check("R9 special write a", bus_rdata, 8'h80);
    wr(8'hC0);
    check("R9 special write b", bus_rdata, 8'hC0);
    wr(8'h40);
    check("R9 special write c", bus_rdata, 8'h40);
    special_mode = 1'b0;
    wr(8'hC0);
    check("R9 no lock from special", bus_rdata, 8'hC0);
    wr(8'h40);
    check("R8 lock after normal write", bus_rdata, 8'hC0);
  endtask

  task automatic t_disable();
    do_reset();
    wr(8'h80);
    irq_pin_n = 1'b0;
    idle(3);
    check("R7 disabled quiet", {7'b0, irq_req}, 8'h00);
    irq_pin_n = 1'b1;
    idle(3);
    wr(8'hC0);
    check("R7 captured edge shown", {7'b0, irq_req}, 8'h01);
    ack_pulse();
  endtask

  task automatic t_collide();
    do_reset();
    wr(8'hC0);
    irq_pin_n = 1'b0;
    idle(3);
    irq_pin_n = 1'b1;
    idle(3);
    irq_pin_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ack_pulse();
    check("R6 edge beats ack", {7'b0, irq_req}, 8'h01);
    ack_pulse();
    check("R5 later ack clears", {7'b0, irq_req}, 8'h00);
    irq_pin_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_lock();
    t_special();
    t_disable();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule